// File: doc/BRIEF.md
# Battery Monitor Low-Power Mode Sequencer

This block decides when a battery monitor may drop out of full operation. It watches the idle level of the single-wire host bus and the pulses from the charge counter. When the host has gone quiet and almost no charge is flowing, it moves the monitor into a sleep state. In that state gauging stops, and the block wakes up at long fixed intervals to take a temperature reading. It can also take the monitor into a deeper ship state, in which nothing runs until the bus is driven high again. That state is only entered after an explicit ship command.

Every timer counts a seconds tick from an internal prescaler. All durations are parameters given in seconds, and the prescale ratio is a parameter as well. The bus input must already be synchronized to the clock. `cnt_evt` is a one-cycle pulse for each charge-counter event. `ship_cmd` is a one-cycle strobe that the register front end raises once the host has set the ship request and then written the execute code. No interface carries a data stream, so every pin is plain level or pulse control. There is no back-pressure.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, `mode` is 0 (active), `gauge_en` is 1, `temp_req` is 0 and no ship request is pending. `mode` encodes active as 0, sleep as 1 and ship as 2. Periodic wakes report 0.
- R2: Leaving active mode requires the bus to be low for LOW_SECS seconds in a row. While no ship request is pending, any high level restarts that count.
- R3: Activity is measured over back-to-back windows of CHECK_SECS seconds. The last completed window is quiet when its event count is strictly below `thr_code`, or below ZERO_THR (default 2) when `thr_code` is 0. Sleep is entered only after a quiet window. The window and the quiet state restart on every entry to active mode.
- R4: In sleep, after WAKE_SECS seconds the block wakes with `mode` 0. It sets `gauge_en` to 1 and pulses `temp_req` for exactly one cycle. `gauge_en` is 0 only in sleep and ship.
- R5: On a short wake with the bus still low, the block returns to sleep after LOW_SECS seconds.
- R6: The 1st wake, and every WAKE_PERIOD-th wake after it (default: wakes 1, 4, 7, ...), is a check wake. It stays awake for one CHECK_SECS window. Afterwards it goes back to sleep if that window was quiet; otherwise it moves to active mode.
- R7: A high bus level in sleep or in any wake moves the block to active mode on the next clock edge. Every entry to active mode clears the wake index, so the next wake is a check wake.
- R8: A `ship_cmd` strobe arms a ship request. While armed, the next low-bus timeout in active mode enters ship (`mode` 2, `gauge_en` 0) whatever the activity level.
- R9: While a ship request is armed, bus high levels hold the low-time count instead of restarting it.
- R10: In ship mode, events, a low bus and elapsed time have no effect and `temp_req` stays 0. A high bus level returns the block to active mode on the next edge.
- R11: Entering ship clears the armed request. After leaving ship, a later low-bus timeout follows the sleep rules and never goes to ship again without a new `ship_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_lvl | input | 1 | Synchronized host bus level |
| cnt_evt | input | 1 | One-cycle pulse per charge-counter event |
| thr_code | input | THR_W | Activity threshold in events per window; 0 selects ZERO_THR |
| ship_cmd | input | 1 | One-cycle strobe that arms a ship request |
| mode | output | 2 | 0 active, 1 sleep, 2 ship |
| gauge_en | output | 1 | High while gauging runs |
| temp_req | output | 1 | One-cycle temperature conversion request on each wake |

## Verification
The embedded properties check the following on every cycle:
- A high bus level leaves sleep, any wake or ship on the next edge.
- Ship is never entered from active mode without an armed request, and the request is already cleared when ship starts.
- Sleep is never entered from active mode without a quiet window and a completed low-time count.
- `temp_req` only follows a sleep cycle.
- The low-time counter holds while armed and clears otherwise.

Only the bench scenarios can show the following:
- The long-range timing: the wake interval and the one-in-three spacing of check wakes.
- That a glitch restarts the low-time count when disarmed but not when armed.
- That a completed ship visit leaves the next timeout heading for sleep.
- The exact boundary where an event count equal to the threshold counts as activity.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_ACT  = 3'd0,
    ST_SLP  = 3'd1,
    ST_WAKE = 3'd2,
    ST_CHK  = 3'd3,
    ST_SHIP = 3'd4
  } lpm_state_t;

  localparam logic [1:0] MODE_ACTIVE = 2'd0;
  localparam logic [1:0] MODE_SLEEP  = 2'd1;
  localparam logic [1:0] MODE_SHIP   = 2'd2;

endpackage

// File: rtl/lpm_sec_tick.sv
module lpm_sec_tick #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  output logic sec_tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (pcnt == PLAST)  pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

  assign sec_tick = (pcnt == PLAST);

  // R4: the time base yields isolated single-cycle ticks
  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

endmodule

// File: rtl/lpm_low_timer.sv
module lpm_low_timer #(
  parameter int LOW_SECS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic bus_lvl,
  input  logic hold,
  input  logic clr,
  output logic low_done
);
  localparam int LW = $clog2(LOW_SECS + 1);
  localparam logic [LW-1:0] LFULL = LW'(LOW_SECS);

  logic [LW-1:0] lcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  lcnt <= '0;
    else if (clr)                                lcnt <= '0;
    else if (bus_lvl && !hold)                   lcnt <= '0;
    else if (!bus_lvl && sec_tick && lcnt != LFULL) lcnt <= lcnt + 1'b1;
  end

  assign low_done = (lcnt == LFULL);

  a_r2_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lvl && !hold) |=> (lcnt == '0));

  a_r9_hold_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lvl && hold && !clr) |=> $stable(lcnt));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lcnt <= LFULL);

endmodule

// File: rtl/lpm_activity.sv
module lpm_activity #(
  parameter int WIN_SECS = 900,
  parameter int THR_W    = 8,
  parameter int ZERO_THR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             run,
  input  logic             restart,
  input  logic             evt,
  input  logic [THR_W-1:0] thr_code,
  output logic             win_done,
  output logic             win_quiet,
  output logic             quiet
);
  localparam int WW = $clog2(WIN_SECS + 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN_SECS - 1);
  localparam int EW = THR_W + 1;
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [THR_W-1:0] ZTHR = THR_W'(ZERO_THR);

  logic [WW-1:0]    win_cnt;
  logic [EW-1:0]    evt_cnt;
  logic [THR_W-1:0] thr_eff;

  assign thr_eff   = (thr_code == '0) ? ZTHR : thr_code;
  assign win_done  = run && sec_tick && (win_cnt == WLAST);
  assign win_quiet = (evt_cnt < {1'b0, thr_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      evt_cnt <= '0;
      quiet   <= 1'b0;
    end else if (restart) begin
      win_cnt <= '0;
      evt_cnt <= '0;
      quiet   <= 1'b0;
    end else if (run) begin
      if (win_done) begin
        win_cnt <= '0;
        evt_cnt <= {{(EW-1){1'b0}}, evt};
        quiet   <= win_quiet;
      end else begin
        if (sec_tick)               win_cnt <= win_cnt + 1'b1;
        if (evt && evt_cnt != EMAX) evt_cnt <= evt_cnt + 1'b1;
      end
    end
  end

  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= WLAST);

  a_r3_restart_clears_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !quiet);

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int TICK_DIV    = 32768,
  parameter int LOW_SECS    = 16,
  parameter int CHECK_SECS  = 900,
  parameter int WAKE_SECS   = 14400,
  parameter int WAKE_PERIOD = 3,
  parameter int THR_W       = 8,
  parameter int ZERO_THR    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_lvl,
  input  logic             cnt_evt,
  input  logic [THR_W-1:0] thr_code,
  input  logic             ship_cmd,
  output logic [1:0]       mode,
  output logic             gauge_en,
  output logic             temp_req
);
  localparam int SW = $clog2(WAKE_SECS + 1);
  localparam logic [SW-1:0] SLAST = SW'(WAKE_SECS - 1);

  lpm_state_t state, state_nxt;
  logic sec_tick, low_done, win_done, win_quiet, quiet;
  logic armed, st_chg, enter_act, enter_ship, wake_due, chk_sel, to_wake;
  logic act_restart, act_run;
  logic [SW-1:0] slp_cnt;

  lpm_sec_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick)
  );

  lpm_low_timer #(.LOW_SECS(LOW_SECS)) u_low (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_lvl(bus_lvl),
    .hold(armed), .clr(st_chg), .low_done(low_done)
  );

  lpm_activity #(.WIN_SECS(CHECK_SECS), .THR_W(THR_W), .ZERO_THR(ZERO_THR)) u_act (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .run(act_run),
    .restart(act_restart), .evt(cnt_evt), .thr_code(thr_code),
    .win_done(win_done), .win_quiet(win_quiet), .quiet(quiet)
  );

  assign wake_due = sec_tick && (slp_cnt == SLAST);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_ACT: begin
        if (low_done && armed)      state_nxt = ST_SHIP;
        else if (low_done && quiet) state_nxt = ST_SLP;
      end
      ST_SLP: begin
        if (bus_lvl)       state_nxt = ST_ACT;
        else if (wake_due) state_nxt = chk_sel ? ST_CHK : ST_WAKE;
      end
      ST_WAKE: begin
        if (bus_lvl)       state_nxt = ST_ACT;
        else if (low_done) state_nxt = ST_SLP;
      end
      ST_CHK: begin
        if (bus_lvl)       state_nxt = ST_ACT;
        else if (win_done) state_nxt = win_quiet ? ST_SLP : ST_ACT;
      end
      ST_SHIP: begin
        if (bus_lvl)       state_nxt = ST_ACT;
      end
      default:             state_nxt = ST_ACT;
    endcase
  end

  assign st_chg      = (state_nxt != state);
  assign enter_act   = st_chg && (state_nxt == ST_ACT);
  assign enter_ship  = st_chg && (state_nxt == ST_SHIP);
  assign to_wake     = (state == ST_SLP) && st_chg && (state_nxt != ST_ACT);
  assign act_restart = enter_act || (st_chg && state_nxt == ST_CHK);
  assign act_run     = (state == ST_ACT) || (state == ST_CHK);

  generate
    if (WAKE_PERIOD < 2) begin : g_every_check
      assign chk_sel = 1'b1;
    end else begin : g_wake_index
      localparam int IW = $clog2(WAKE_PERIOD);
      localparam logic [IW-1:0] ILAST = IW'(WAKE_PERIOD - 1);
      logic [IW-1:0] widx;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         widx <= '0;
        else if (enter_act) widx <= '0;
        else if (to_wake)   widx <= (widx == ILAST) ? '0 : widx + 1'b1;
      end
      assign chk_sel = (widx == '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ACT;
      slp_cnt  <= '0;
      armed    <= 1'b0;
      temp_req <= 1'b0;
    end else begin
      state    <= state_nxt;
      temp_req <= to_wake;
      if (st_chg || state != ST_SLP) slp_cnt <= '0;
      else if (sec_tick)             slp_cnt <= slp_cnt + 1'b1;
      if (enter_ship)    armed <= 1'b0;
      else if (ship_cmd) armed <= 1'b1;
    end
  end

  always_comb begin
    unique case (state)
      ST_SLP:  mode = MODE_SLEEP;
      ST_SHIP: mode = MODE_SHIP;
      default: mode = MODE_ACTIVE;
    endcase
  end

  assign gauge_en = (state != ST_SLP) && (state != ST_SHIP);

  a_r7_bus_high_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SLP || state == ST_WAKE || state == ST_CHK) && bus_lvl)
      |=> (state == ST_ACT));

  a_r10_ship_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIP && bus_lvl) |=> (mode == MODE_ACTIVE));

  a_r10_ship_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIP && !bus_lvl) |=> (state == ST_SHIP && !temp_req));

  a_r8_ship_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT && !armed) |=> (state != ST_SHIP));

  a_r11_arm_cleared_in_ship: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_SHIP) |-> !armed);

  a_r3_sleep_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT && !(low_done && quiet)) |=> (state != ST_SLP));

  a_r4_temp_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    temp_req |-> ((state == ST_WAKE || state == ST_CHK) && $past(state) == ST_SLP));

endmodule

// File: tb/sim_lpm_sequencer.sv
module sim_lpm_sequencer;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus = 1'b1;
  logic evt = 1'b0;
  logic ship = 1'b0;
  logic [7:0] thr = 8'd0;
  logic [1:0] mode;
  logic gauge_en, temp_req;

  int n_chk = 0;
  int n_bad = 0;
  int n_temp = 0;

  always #5 clk = ~clk;

  lpm_sequencer #(
    .TICK_DIV(TDIV), .LOW_SECS(16), .CHECK_SECS(24), .WAKE_SECS(40),
    .WAKE_PERIOD(3), .THR_W(8), .ZERO_THR(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_lvl(bus), .cnt_evt(evt), .thr_code(thr),
    .ship_cmd(ship), .mode(mode), .gauge_en(gauge_en), .temp_req(temp_req)
  );

  always @(negedge clk) if (rst_n && temp_req) n_temp++;

  // [21] bus, [20:17] events, [16:7] seconds, [6:5] mode, [4] gauge_en, [3:0] requirement number
  localparam logic [21:0] VEC [0:13] = '{
    {1'b1, 4'd0, 10'd2,  2'd0, 1'b1, 4'd1},  // R1 t=2
    {1'b0, 4'd3, 10'd20, 2'd0, 1'b1, 4'd3},  // R3 t=22 low done, no quiet window
    {1'b0, 4'd0, 10'd8,  2'd0, 1'b1, 4'd3},  // R3 t=30 window of 3 events is busy
    {1'b0, 4'd0, 10'd20, 2'd1, 1'b0, 4'd2},  // R2 t=50 sleep after quiet window
    {1'b0, 4'd0, 10'd30, 2'd1, 1'b0, 4'd4},  // R4 t=80
    {1'b0, 4'd0, 10'd20, 2'd0, 1'b1, 4'd6},  // R6 t=100 first wake is a check
    {1'b0, 4'd0, 10'd20, 2'd1, 1'b0, 4'd6},  // R6 t=120
    {1'b0, 4'd0, 10'd40, 2'd0, 1'b1, 4'd4},  // R4 t=160 second wake
    {1'b0, 4'd0, 10'd16, 2'd1, 1'b0, 4'd5},  // R5 t=176
    {1'b0, 4'd0, 10'd40, 2'd0, 1'b1, 4'd5},  // R5 t=216 third wake
    {1'b0, 4'd0, 10'd16, 2'd1, 1'b0, 4'd5},  // R5 t=232
    {1'b0, 4'd0, 10'd40, 2'd0, 1'b1, 4'd6},  // R6 t=272 fourth wake
    {1'b0, 4'd0, 10'd12, 2'd0, 1'b1, 4'd6},  // R6 t=284 still awake: long check
    {1'b0, 4'd0, 10'd10, 2'd1, 1'b0, 4'd6}   // R6 t=294
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic run(input logic b, input int nev, input int secs);
    for (int c = 0; c < secs * TDIV; c++) begin
      @(negedge clk);
      bus = b;
      evt = (c < 2 * nev) && (c % 2 == 0);
    end
    evt = 1'b0;
  endtask

  task automatic wake_up(input string req);
    @(negedge clk);
    bus = 1'b1;
    @(negedge clk);
    chk(req, "mode after bus high", int'(mode), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "gauge_en", int'(gauge_en), 1);
    chk("R1", "temp_req", int'(temp_req), 0);

    for (int i = 0; i < 14; i++) begin
      string rq;
      rq = $sformatf("R%0d", int'(VEC[i][3:0]));
      run(VEC[i][21], int'(VEC[i][20:17]), int'(VEC[i][16:7]));
      chk(rq, $sformatf("mode step %0d", i), int'(mode), int'(VEC[i][6:5]));
      chk(rq, $sformatf("gauge_en step %0d", i), int'(gauge_en), int'(VEC[i][4]));
    end
    chk("R4", "temperature requests after four wakes", n_temp, 4);

    // R7: high exits sleep at once; wake index restarts so next wake is a check
    wake_up("R7");
    run(1'b0, 0, 84);
    chk("R7", "check wake after index reset", int'(mode), 0);
    run(1'b0, 0, 8);
    chk("R6", "sleep after quiet check", int'(mode), 1);

    // R2: a high glitch restarts the low count when no ship request is armed
    run(1'b1, 0, 30);
    chk("R7", "active on bus high", int'(mode), 0);
    run(1'b0, 0, 10);
    run(1'b1, 0, 1);
    run(1'b0, 0, 10);
    chk("R2", "glitch restarted low count", int'(mode), 0);
    run(1'b0, 0, 8);
    chk("R2", "sleep after full low count", int'(mode), 1);

    // R3: nonzero threshold, 3 events below 5 is quiet
    thr = 8'd5;
    wake_up("R7");
    run(1'b0, 3, 30);
    chk("R3", "3 events under code 5 is quiet", int'(mode), 1);
    // R3: count equal to threshold is activity
    wake_up("R7");
    run(1'b0, 5, 30);
    chk("R3", "5 events at code 5 is busy", int'(mode), 0);
    run(1'b0, 0, 20);
    chk("R3", "sleep after next quiet window", int'(mode), 1);
    thr = 8'd0;

    // R8, R9: armed ship taken on timeout, glitch holds the count
    wake_up("R7");
    @(negedge clk); ship = 1'b1;
    @(negedge clk); ship = 1'b0;
    run(1'b0, 4, 5);
    run(1'b1, 0, 3);
    run(1'b0, 0, 13);
    chk("R9", "glitch held count, ship mode", int'(mode), 2);
    chk("R8", "gauge_en in ship", int'(gauge_en), 0);

    // R10: ship ignores events and time, no wakes
    t0 = n_temp;
    run(1'b0, 6, 100);
    chk("R10", "still in ship", int'(mode), 2);
    chk("R10", "no temperature requests in ship", n_temp, t0);
    wake_up("R10");

    // R11: request consumed, next timeout follows sleep rules
    run(1'b0, 0, 20);
    chk("R11", "no ship re-entry at timeout", int'(mode), 0);
    run(1'b0, 0, 10);
    chk("R11", "sleep after quiet window", int'(mode), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule